// File: doc/BRIEF.md
# SDRAM Data Mask Pipeline

This block implements the byte-mask part of an SDRAM data path. One mask input per byte lane has two jobs, and which job it does depends on the transfer direction. During reads the mask acts as an output enable that is applied two clock cycles after the mask is sampled. During writes the mask acts as a byte mask in the same cycle, which decides whether each byte of the incoming word is stored.

Read data and write data use separate ports rather than one tristate bus. A disabled read lane is reported by a low per-lane output-enable bit, which stands for the high-impedance state, and that lane's data bits are forced to zero. The write side produces a per-byte write enable and a masked copy of the write data for the storage array.

A parameter selects between two widths. The x8 width has one lane. The x16 width has two lanes: bit 0 of the mask is the lower-byte mask and covers data bits 7:0, and bit 1 is the upper-byte mask and covers data bits 15:8. The memory array, the CAS-latency path and the burst counter sit outside this block.

Top module: `dqm_mask_pipe`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after it is released, every bit of `rdOutEn` is 0 (high impedance) and `rdDataOut` is 0.
- R2: The value of `rdOutEn[k]` seen after a rising edge is the inverse of `maskIn[k]` sampled two rising edges earlier, provided `writeMode` was 0 at that earlier edge.
- R3: When `rdOutEn[k]` is 0, byte k of `rdDataOut` is 0. When `rdOutEn[k]` is 1, byte k of `rdDataOut` equals byte k of `rdDataIn`.
- R4: While `writeMode` is 1, `wrByteEn[k]` equals the inverse of `maskIn[k]` in the same cycle, with no clock delay.
- R5: While `writeMode` is 1, byte k of `wrDataOut` equals byte k of `wrDataIn` when `maskIn[k]` is 0. It is 0 when `maskIn[k]` is 1.
- R6: While `writeMode` is 0, every bit of `wrByteEn` is 0 and `wrDataOut` is 0.
- R7: A cycle sampled with `writeMode` = 1 disables every read lane two rising edges later, whatever the mask value.
- R8: Byte lanes are independent. In x16 mode, bit 0 of `maskIn` (lower byte, data bits 7:0) and bit 1 (upper byte, data bits 15:8) each have their own delay pipeline and write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| writeMode | input | 1 | 1 = write transfer, 0 = read transfer |
| maskIn | input | LANES | Per-lane mask; bit 0 = lower byte, bit 1 = upper byte (x16) |
| rdDataIn | input | 8*LANES | Read data from the array |
| wrDataIn | input | 8*LANES | Write data from the pins |
| rdDataOut | output | 8*LANES | Read data, zero on disabled lanes |
| rdOutEn | output | LANES | Per-lane read output enable (0 = high impedance) |
| wrByteEn | output | LANES | Per-lane write enable |
| wrDataOut | output | 8*LANES | Write data, zero on masked lanes |

## Verification
The vector walk tries all four mask combinations in read mode, then all four in write mode, then returns to read. The read phase tells the two-cycle output-enable delay apart from an immediate or one-cycle delay. The write phase separates the zero-latency byte mask from the delayed one, and the write-to-read return shows that write cycles disable the read lanes afterwards. Asymmetric masks such as 01 and 10 expose swapped or shared lanes, and a reset applied in the middle of the run shows that the enables are cleared at once.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  localparam int MAX_LANES = 2;
  localparam int BYTE_W    = 8;
  localparam int RD_LAT    = 2;

  typedef struct packed {
    logic [MAX_LANES-1:0] rdEn;
    logic [MAX_LANES-1:0] wrEn;
  } laneStrb_t;
endpackage

// File: rtl/dqm_ctrl.sv
module dqm_ctrl
  import dqm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             writeMode,
  input  logic [LANES-1:0] maskIn,
  output laneStrb_t        strb
);
  logic [MAX_LANES-1:0] rdEnAll;
  logic [MAX_LANES-1:0] wrEnAll;
  logic [1:0]           warmCnt;

  // Edges since reset release, saturating; used only to bound assertion lookback.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 warmCnt <= 2'd0;
    else if (warmCnt != 2'd2)  warmCnt <= warmCnt + 2'd1;
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : gLane
    if (g < LANES) begin : gLive
      // One bit per stage; 1 means the lane is disabled.
      logic [RD_LAT-1:0] offPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) offPipe <= '1;
        else       offPipe <= {offPipe[RD_LAT-2:0], maskIn[g] | writeMode};
      end
      assign rdEnAll[g] = ~offPipe[RD_LAT-1];
      assign wrEnAll[g] = writeMode & ~maskIn[g];

      a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt == 2'd2) |-> (rdEnAll[g] == !($past(maskIn[g], 2) || $past(writeMode, 2))));
      a_r7_write_blanks_read: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt == 2'd2 && $past(writeMode, 2)) |-> !rdEnAll[g]);
    end else begin : gIdle
      assign rdEnAll[g] = 1'b0;
      assign wrEnAll[g] = 1'b0;
    end
  end

  assign strb.rdEn = rdEnAll;
  assign strb.wrEn = wrEnAll;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt != 2'd2) |-> (strb.rdEn == '0));
  a_r6_read_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !writeMode |-> (strb.wrEn == '0));
endmodule

// File: rtl/dqm_datapath.sv
module dqm_datapath
  import dqm_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DW   = LANES * BYTE_W
) (
  input  laneStrb_t        strb,
  input  logic [DW-1:0]    rdDataIn,
  input  logic [DW-1:0]    wrDataIn,
  output logic [DW-1:0]    rdDataOut,
  output logic [LANES-1:0] rdOutEn,
  output logic [LANES-1:0] wrByteEn,
  output logic [DW-1:0]    wrDataOut
);
  for (genvar g = 0; g < LANES; g++) begin : gByte
    assign rdOutEn[g]  = strb.rdEn[g];
    assign wrByteEn[g] = strb.wrEn[g];
    assign rdDataOut[g*BYTE_W +: BYTE_W] =
      strb.rdEn[g] ? rdDataIn[g*BYTE_W +: BYTE_W] : '0;
    assign wrDataOut[g*BYTE_W +: BYTE_W] =
      strb.wrEn[g] ? wrDataIn[g*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/dqm_mask_pipe.sv
module dqm_mask_pipe
  import dqm_pkg::*;
#(
  parameter bit  X16  = 1'b1,
  localparam int LANES = X16 ? 2 : 1,
  localparam int DW    = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             writeMode,
  input  logic [LANES-1:0] maskIn,
  input  logic [DW-1:0]    rdDataIn,
  input  logic [DW-1:0]    wrDataIn,
  output logic [DW-1:0]    rdDataOut,
  output logic [LANES-1:0] rdOutEn,
  output logic [LANES-1:0] wrByteEn,
  output logic [DW-1:0]    wrDataOut
);
  laneStrb_t strb;

  dqm_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .writeMode (writeMode),
    .maskIn    (maskIn),
    .strb      (strb)
  );

  dqm_datapath #(.LANES(LANES)) u_data (
    .strb      (strb),
    .rdDataIn  (rdDataIn),
    .wrDataIn  (wrDataIn),
    .rdDataOut (rdDataOut),
    .rdOutEn   (rdOutEn),
    .wrByteEn  (wrByteEn),
    .wrDataOut (wrDataOut)
  );

  for (genvar g = 0; g < LANES; g++) begin : gChk
    a_r5_masked_write_zero: assert property (@(posedge clk) disable iff (!rstN)
      (writeMode && maskIn[g]) |-> (wrDataOut[g*BYTE_W +: BYTE_W] == '0));
    a_r4_write_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
      (writeMode && !maskIn[g]) |-> (wrByteEn[g] &&
        wrDataOut[g*BYTE_W +: BYTE_W] == wrDataIn[g*BYTE_W +: BYTE_W]));
    a_r3_off_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
      !rdOutEn[g] |-> (rdDataOut[g*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: tb/dqm_mask_pipe_tb.sv
module dqm_mask_pipe_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        writeMode = 1'b0;
  logic [1:0]  maskIn = 2'b00;
  logic [15:0] rdDataIn = '0;
  logic [15:0] wrDataIn = '0;
  logic [15:0] rdDataOut;
  logic [1:0]  rdOutEn;
  logic [1:0]  wrByteEn;
  logic [15:0] wrDataOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dqm_mask_pipe #(.X16(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .writeMode(writeMode), .maskIn(maskIn),
    .rdDataIn(rdDataIn), .wrDataIn(wrDataIn), .rdDataOut(rdDataOut),
    .rdOutEn(rdOutEn), .wrByteEn(wrByteEn), .wrDataOut(wrDataOut)
  );

  // {writeMode, mask[1:0], rdData, wrData}
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 2'b00, 16'hA1B2, 16'h1111},
    {1'b0, 2'b01, 16'hC3D4, 16'h2222},
    {1'b0, 2'b10, 16'hE5F6, 16'h3333},
    {1'b0, 2'b11, 16'h0718, 16'h4444},
    {1'b1, 2'b00, 16'h292A, 16'h5B6C},
    {1'b1, 2'b01, 16'h3B3C, 16'h7D8E},
    {1'b1, 2'b10, 16'h4D4E, 16'h9FA0},
    {1'b1, 2'b11, 16'h5F60, 16'hB1C2},
    {1'b0, 2'b00, 16'h6172, 16'hD3E4},
    {1'b0, 2'b10, 16'h8394, 16'hF506},
    {1'b0, 2'b01, 16'hA5B6, 16'h1728},
    {1'b0, 2'b00, 16'hC7D8, 16'h394A}
  };

  function automatic logic [15:0] gate(input logic [15:0] d, input logic [1:0] en);
    return {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rdDataIn = 16'hFFFF;
    #1;
    check("R1 rdOutEn in reset", {14'd0, rdOutEn}, 16'h0);
    check("R1 rdDataOut in reset", rdDataOut, 16'h0);
    rstN = 1'b1;

    // Vector walk: read (R2,R3,R8), write (R4,R5,R7), back to read (R6)
    for (int i = 0; i < 12; i++) begin
      logic [1:0]  expEn;
      logic [1:0]  expWr;
      if (i > 0) @(negedge clk);
      writeMode = VEC[i][34];
      maskIn    = VEC[i][33:32];
      rdDataIn  = VEC[i][31:16];
      wrDataIn  = VEC[i][15:0];
      #1;
      if (i < 2) expEn = 2'b00;  // R1: pipeline still holds reset
      else       expEn = ~(VEC[i-2][33:32] | {2{VEC[i-2][34]}});
      expWr = VEC[i][34] ? ~VEC[i][33:32] : 2'b00;
      check("R2/R7/R8 rdOutEn", {14'd0, rdOutEn}, {14'd0, expEn});
      check("R3 rdDataOut", rdDataOut, gate(VEC[i][31:16], expEn));
      check("R4/R6 wrByteEn", {14'd0, wrByteEn}, {14'd0, expWr});
      check("R5/R6 wrDataOut", wrDataOut, gate(VEC[i][15:0], expWr));
    end

    // R2: steady read, one-cycle mask pulse on the upper lane shows exactly two cycles later
    @(negedge clk); writeMode = 1'b0; maskIn = 2'b00; rdDataIn = 16'h1234;
    @(negedge clk); maskIn = 2'b10;
    @(negedge clk); maskIn = 2'b00; #1;
    check("R2 pulse not yet visible", {14'd0, rdOutEn}, 16'h0003);
    @(negedge clk); #1;
    check("R2 pulse visible after two edges", {14'd0, rdOutEn}, 16'h0001);
    check("R3 upper byte zeroed", rdDataOut, 16'h0034);
    @(negedge clk); #1;
    check("R2 pulse gone", {14'd0, rdOutEn}, 16'h0003);

    // R1: asynchronous reset mid-run clears the enables at once
    rstN = 1'b0; #1;
    check("R1 mid-run reset rdOutEn", {14'd0, rdOutEn}, 16'h0);
    check("R1 mid-run reset rdDataOut", rdDataOut, 16'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 first edge after release", {14'd0, rdOutEn}, 16'h0);
    @(negedge clk); #1;
    check("R2 enabled after two edges", {14'd0, rdOutEn}, 16'h0003);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule